// File: doc/BRIEF.md
# Keyed Random-Word Register Front End

This block sits between a free-running entropy source and a simple 32-bit register bus. The entropy source presents 32-bit words with a valid strobe, and the block keeps the most recent one in a pool register. While generation is enabled, a pacing counter produces a new output word at a fixed interval. At each such event the current entropy word is latched into the output data register and a ready flag is raised.

Software turns generation on and off through a control register. A write there takes effect only if its upper 24 bits carry a fixed key. A mode register bit doubles the pacing interval. The ready flag clears when the status register is read, so software that polls status and then reads data never sees the same word reported twice.

Reads are combinational: read data is valid in the same cycle as the read strobe and is zero when no read is requested. Writes and read side effects take place on the rising clock edge.

Top module: `rngf_top`

## Requirements
- R1: Register offsets are control 0x00 (bit 0 reads the enable state), mode 0x04 (bit 0 reads half-rate select), status 0x1C (bit 0 is ready) and data 0x50 (full 32-bit word). When `bus_re` is low, `bus_rdata` is zero.
- R2: A write to 0x00 whose bits [31:8] equal 0x524E47 loads the enable state from bit 0. A 1 enables generation and a 0 disables it.
- R3: A write to 0x00 with any other value in bits [31:8] leaves the enable state unchanged.
- R4: At normal rate (mode bit 0 = 0), the first word is produced on the 84th rising edge after the keyed enable edge, and every 84 edges after that.
- R5: With mode bit 0 = 1 (half rate), words are produced every 168 edges. Writes to 0x04 need no key.
- R6: While disabled, no word is produced and the data register holds its value. Re-enabling restarts the interval count from zero.
- R7: Ready is set by a produced word. A status read clears it on that edge, and it stays clear until the next word is produced.
- R8: If a status read and a produced word fall on the same edge, ready ends set.
- R9: A produced word equals `ent_word` if `ent_valid` is high on that edge. Otherwise it equals the last `ent_word` accepted with `ent_valid`, or zero if none has been accepted.
- R10: Synchronous reset clears the enable, mode, ready, the entropy pool and the data register to zero.
- R11: Reads of any other offset return zero. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (status read clears ready) |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| ent_word | input | 32 | Entropy word from the source |
| ent_valid | input | 1 | Entropy word valid strobe |

## Verification
A wrong pacing count appears as a ready flag that rises one or more cycles off its expected edge. The bench probes status on the cycle before and the cycle after the expected word, and compares status every cycle against a reference, so an error of a single cycle is reported at once. A wrong enable or key decode shows as a control readback that differs on the next cycle. A wrong pool or capture rule shows up at the first data read after a word is produced. A wrong priority between clear and set is exposed by the read deliberately placed on the production edge.

// File: rtl/rngf_pkg.sv
package rngf_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int KEY_W   = 24;

    localparam logic [KEY_W-1:0]  CTRL_KEY = 24'h524E47;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_DATA = 8'h50;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_MODE,
        SEL_STAT,
        SEL_DATA
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic half;
    } cfg_t;

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] word;
    } out_t;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_CTRL: s = SEL_CTRL;
            OFF_MODE: s = SEL_MODE;
            OFF_STAT: s = SEL_STAT;
            OFF_DATA: s = SEL_DATA;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic key_match(input logic [KEY_W-1:0] k);
        return k == CTRL_KEY;
    endfunction
endpackage

// File: rtl/rngf_ctrl.sv
module rngf_ctrl
    import rngf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [KEY_W-1:0] key_field,
    input  logic             lsb,
    output cfg_t             cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            if (sel == SEL_CTRL && key_match(key_field))
                cfg_q.en <= lsb;
            if (sel == SEL_MODE)
                cfg_q.half <= lsb;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/rngf_pacer.sv
module rngf_pacer
    import rngf_pkg::*;
#(
    parameter int PERIOD = 84
) (
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    output logic tick
);
    localparam int CNT_W = $clog2(2 * PERIOD);
    localparam logic [CNT_W-1:0] LIM_NORM = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(2 * PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = cfg.half ? LIM_HALF : LIM_NORM;
    assign tick  = cfg.en && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !cfg.en)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rngf_capture.sv
module rngf_capture
    import rngf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              clr,
    input  logic [DATA_W-1:0] ent_word,
    input  logic              ent_valid,
    output out_t              out
);
    logic [DATA_W-1:0] pool_q;
    logic [DATA_W-1:0] fresh;
    out_t              out_q;

    assign fresh = ent_valid ? ent_word : pool_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pool_q <= '0;
            out_q  <= '0;
        end else begin
            if (ent_valid)
                pool_q <= ent_word;
            if (tick) begin
                out_q.word  <= fresh;
                out_q.ready <= 1'b1;
            end else if (clr) begin
                out_q.ready <= 1'b0;
            end
        end
    end

    assign out = out_q;
endmodule

// File: rtl/rngf_top.sv
module rngf_top
    import rngf_pkg::*;
#(
    parameter int PERIOD = 84
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] ent_word,
    input  logic              ent_valid
);
    reg_sel_e sel;
    cfg_t     cfg;
    out_t     out;
    logic     tick;
    logic     stat_rd;

    assign sel     = decode(bus_addr);
    assign stat_rd = bus_re && (sel == SEL_STAT);

    rngf_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_we),
        .sel       (sel),
        .key_field (bus_wdata[DATA_W-1:DATA_W-KEY_W]),
        .lsb       (bus_wdata[0]),
        .cfg       (cfg)
    );

    rngf_pacer #(.PERIOD(PERIOD)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .tick (tick)
    );

    rngf_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .clr       (stat_rd),
        .ent_word  (ent_word),
        .ent_valid (ent_valid),
        .out       (out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (sel)
                SEL_CTRL: bus_rdata[0] = cfg.en;
                SEL_MODE: bus_rdata[0] = cfg.half;
                SEL_STAT: bus_rdata[0] = out.ready;
                SEL_DATA: bus_rdata    = out.word;
                default:  bus_rdata    = '0;
            endcase
        end
    end
endmodule

// File: rtl/rngf_chk.sv
module rngf_chk
    import rngf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick,
    input cfg_t              cfg,
    input out_t              out
);
    // R3
    badkey_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CTRL && bus_wdata[31:8] != CTRL_KEY) |=> $stable(cfg.en));

    // R2
    goodkey_loads_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CTRL && bus_wdata[31:8] == CTRL_KEY) |=> (cfg.en == $past(bus_wdata[0])));

    // R6
    no_word_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !tick);

    // R7
    ready_on_word_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> out.ready);

    // R7
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == OFF_STAT && !tick) |=> !out.ready);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(out.word));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr != OFF_CTRL && bus_addr != OFF_MODE &&
         bus_addr != OFF_STAT && bus_addr != OFF_DATA) |-> bus_rdata == '0);
endmodule

bind rngf_top rngf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .tick      (tick),
    .cfg       (cfg),
    .out       (out)
);

// File: tb/rngf_top_test.sv
`timescale 1ns/1ps
module rngf_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] ent_word = 32'h1;
    logic        ent_valid = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [31:0] lfsr = 32'hACE1_2357;

    // behavioural reference
    logic        m_en = 0, m_half = 0, m_rdy = 0;
    logic [31:0] m_pool = 0, m_data = 0;
    int          m_cnt = 0;

    rngf_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .ent_word(ent_word), .ent_valid(ent_valid)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        int  per;
        bit  word_now;
        cyc <= cyc + 1;
        if (rst) begin
            m_en <= 0; m_half <= 0; m_rdy <= 0; m_pool <= 0; m_data <= 0; m_cnt <= 0;
        end else begin
            per = m_half ? 168 : 84;
            word_now = m_en && (m_cnt + 1 >= per);
            if (!m_en || word_now) m_cnt <= 0; else m_cnt <= m_cnt + 1;
            if (ent_valid) m_pool <= ent_word;
            if (word_now) begin
                m_data <= ent_valid ? ent_word : m_pool;
                m_rdy  <= 1;
            end else if (bus_re && bus_addr == 8'h1C) begin
                m_rdy <= 0;
            end
            if (bus_we && bus_addr == 8'h00 && bus_wdata[31:8] == 24'h524E47) m_en <= bus_wdata[0];
            if (bus_we && bus_addr == 8'h04) m_half <= bus_wdata[0];
        end
    end

    function automatic logic [31:0] model_read(input logic re, input logic [7:0] a);
        if (!re) return 32'h0;
        case (a)
            8'h00: return {31'h0, m_en};
            8'h04: return {31'h0, m_half};
            8'h1C: return {31'h0, m_rdy};
            8'h50: return m_data;
            default: return 32'h0;
        endcase
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        logic [31:0] exp_v;
        #1;
        if (!rst) begin
            exp_v = model_read(bus_re, bus_addr);
            checks++;
            if (bus_rdata !== exp_v) begin
                failures++;
                $display("FAIL %s cycle %0d addr %h: got %h exp %h",
                         !bus_re ? "R1" : bus_addr == 8'h50 ? "R9" : bus_addr == 8'h1C ? "R7" :
                         bus_addr == 8'h00 ? "R2" : bus_addr == 8'h04 ? "R5" : "R11",
                         cyc, bus_addr, bus_rdata, exp_v);
            end
        end
    end

    // entropy stand-in
    always @(negedge clk) begin
        lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        ent_word  <= lfsr;
        ent_valid <= (cyc % 3) != 1;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp_v);
        checks++;
        if (got !== exp_v) begin
            failures++;
            $display("FAIL %s: got %h exp %h", tag, got, exp_v);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp_v, input string tag);
        bus_addr = a; bus_re = 1;
        #1;
        check(tag, bus_rdata, exp_v);
        @(negedge clk);
        bus_re = 0;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    initial begin
        int e;
        logic [31:0] saved;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        bus_read(8'h00, 32'h0, "R10 ctrl");
        bus_read(8'h04, 32'h0, "R10 mode");
        bus_read(8'h1C, 32'h0, "R10 status");
        bus_read(8'h50, 32'h0, "R10 data");
        // R3 wrong key
        bus_write(8'h00, 32'h12345601);
        bus_read(8'h00, 32'h0, "R3 bad key");
        // R11 unmapped
        bus_write(8'h08, 32'hFFFFFFFF);
        bus_read(8'h08, 32'h0, "R11 unmapped read");
        bus_read(8'h00, 32'h0, "R11 ctrl untouched");
        bus_read(8'h04, 32'h0, "R11 mode untouched");
        // R2 keyed enable, R4 interval
        bus_write(8'h00, 32'h524E4701);
        e = cyc;
        bus_read(8'h00, 32'h1, "R2 enable");
        bus_read(8'h1C, 32'h0, "R1 status idle");
        wait_until(e + 83);
        bus_read(8'h1C, 32'h0, "R4 before first word");
        bus_read(8'h1C, 32'h1, "R8 read on word edge keeps ready");
        bus_read(8'h1C, 32'h0, "R7 cleared by read");
        saved = m_data;
        bus_read(8'h50, saved, "R9 data word");
        // R6 disable
        bus_write(8'h00, 32'h524E4700);
        bus_read(8'h00, 32'h0, "R6 disabled");
        repeat (300) @(negedge clk);
        bus_read(8'h1C, 32'h0, "R6 no word");
        bus_read(8'h50, saved, "R6 data held");
        // R5 half rate
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, 32'h1, "R5 mode readback");
        bus_write(8'h00, 32'h524E4701);
        e = cyc;
        wait_until(e + 167);
        bus_read(8'h1C, 32'h0, "R5 before half-rate word");
        bus_read(8'h1C, 32'h1, "R5 half-rate word");
        // R3 bad-key disable attempt
        bus_write(8'h00, 32'h00000000);
        bus_read(8'h00, 32'h1, "R3 bad key disable ignored");
        // R4 second interval at normal rate
        bus_write(8'h04, 32'h0);
        repeat (400) @(negedge clk);
        bus_read(8'h1C, 32'h1, "R4 periodic words");
        bus_read(8'h20, 32'h0, "R11 unmapped 0x20");
        repeat (5) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule